// File: doc/BRIEF.md
# Light-Sleep Entry and Peripheral Clock Gating Controller

This block decides when a small processor subsystem drops into a light sleep state and when it comes back out. The core raises one-cycle strobes when it runs a wait-for-interrupt or a wait-for-event instruction, or when it returns from an exception. The controller combines each strobe with three inputs: a deep-sleep select bit, a nap-on-return bit, and the pending interrupt and pending event flags. From these it either stops the core clock or lets execution carry on.

While the subsystem sleeps, each peripheral keeps its clock only if both its run-enable bit and its own nap-enable bit are set. A peripheral whose run-enable bit is clear gets no clock at all. Every enable leaves the block from a register, so the downstream clock gates only ever see glitch-free levels.

An event that arrives while the core is awake is held in a one-bit register. A later wait-for-event consumes that bit and returns at once instead of sleeping. Deeper power states and flash wake timing are handled elsewhere.

Top module: `nap_ctrl`

## Requirements
- R1: A `wfi_req` strobe while awake, with `deep_sel`=0 and `irq_pend`=0 in that cycle, puts the block to sleep at the next clock edge. With `irq_pend`=1 in that cycle it stays awake.
- R2: A `wfe_req` strobe while awake, with `deep_sel`=0, `evt_pend`=0 and no held event, puts the block to sleep at the next edge. With `evt_pend`=1 it stays awake.
- R3: An `exc_ret` strobe while awake puts the block to sleep only when `deep_sel`=0, `exit_nap`=1 and `irq_pend`=0 in that cycle.
- R4: While asleep, bit i of `periph_clk_en` is 0 whenever bit i of `nap_en` is 0, even if bit i of `run_en` is 1. With both bits at 1 the bit stays 1.
- R5: Bit i of `periph_clk_en` is 0 in both the awake and the asleep state whenever bit i of `run_en` is 0. While awake it equals bit i of `run_en`.
- R6: With `deep_sel`=1, none of the three strobes causes light sleep.
- R7: After entry by wait-for-interrupt or by nap-on-return, `irq_pend`=1 wakes the block at the next edge. Events do not wake it.
- R8: After entry by wait-for-event, `evt_pend`=1 wakes the block at the next edge. `irq_pend` alone does not wake it.
- R9: An event seen while not in event-wait sleep is held. The next `wfe_req` with `deep_sel`=0 clears the held bit and does not sleep. The `wfe_req` after that sleeps.
- R10: All outputs are registered. A change on any input shows at the outputs only after the next rising clock edge.
- R11: `napping` is 1 exactly when `core_clk_en` is 0.
- R12: While `rst_n` is low at a clock edge, the block sets `core_clk_en`=1, `napping`=0 and `periph_clk_en`=0, and clears the held event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| wfe_req | input | 1 | Wait-for-event strobe from the core |
| deep_sel | input | 1 | 1 selects the deeper power states; light sleep is then blocked |
| exit_nap | input | 1 | 1 enables automatic sleep on exception return |
| exc_ret | input | 1 | Exception-return strobe |
| irq_pend | input | 1 | An interrupt is pending |
| evt_pend | input | 1 | An event is present |
| run_en | input | N_PERIPH | Per-peripheral clock enable in the awake state |
| nap_en | input | N_PERIPH | Per-peripheral clock enable while asleep |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | N_PERIPH | Gated peripheral clock enables |
| napping | output | 1 | Sleep status |

## Verification
The bench builds the block with N_PERIPH=4. At that width, `run_en` and `nap_en` patterns such as 0110 and 0011 place every combination of the two bits (off/off, on/off, off/on, on/on) on a different peripheral in a single sleep episode. That lets one comparison per state show the gating rule for every case. The directed scenarios cover:
- each entry path together with the condition that blocks it;
- a wake source that does not match the entry path;
- an event captured during interrupt-wait sleep and then consumed by the next wait-for-event.

// File: rtl/nap_pkg.sv
// Package: shared types for the light-sleep controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nap_pkg;

    // Records which source is allowed to end the current sleep episode.
    typedef enum logic {
        WAKE_ON_IRQ = 1'b0,
        WAKE_ON_EVT = 1'b1
    } wake_src_t;

endpackage

// File: rtl/nap_evt_hold.sv
// Module: one-bit event holding register.
// Captures an event seen outside event-wait sleep. A wait-for-event
// request consumes the held bit. An event that ends an event-wait sleep is
// used up by the wake and is not held.
// Assumes: consume_i is only raised for a wait-for-event that is allowed to act.
module nap_evt_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic consume_i,
    input  logic evt_sleep_i,
    output logic held_o
);

    logic held_q;

    // Set on a new event, clear on consume or during event-wait sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (consume_i || evt_sleep_i)
            held_q <= 1'b0;
        else if (evt_i)
            held_q <= 1'b1;
    end

    assign held_o = held_q;

    // R9: a consuming request always leaves the held bit clear.
    p_consume_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !held_q);

endmodule

// File: rtl/nap_entry_fsm.sv
// Module: sleep entry and wake decision.
// Evaluates the three entry paths against the deep-sleep select and the
// pending flags, remembers which source may end the sleep, and registers
// the core clock enable and the status flag.
// Assumes: request strobes are one cycle wide. Requests that arrive while
// asleep are ignored.
module nap_entry_fsm
    import nap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic deep_sel,
    input  logic exit_nap,
    input  logic exc_ret,
    input  logic irq_pend,
    input  logic evt_pend,
    input  logic evt_held,
    output logic consume_o,
    output logic evt_sleep_o,
    output logic sleep_nx_o,
    output logic core_en_o,
    output logic asleep_o
);

    logic      asleep_q;
    logic      core_en_q;
    wake_src_t src_q;
    wake_src_t src_nx;
    logic      awake_ok;
    logic      enter_irq;
    logic      enter_evt;
    logic      wake;
    logic      sleep_nx;

    // Decide entry, wake and the next wake source for this cycle.
    always_comb begin
        awake_ok  = !asleep_q && !deep_sel;
        consume_o = awake_ok && wfe_req;
        enter_irq = awake_ok && !irq_pend && (wfi_req || (exc_ret && exit_nap));
        enter_evt = consume_o && !evt_pend && !evt_held && !enter_irq;
        wake      = asleep_q && ((src_q == WAKE_ON_EVT) ? evt_pend : irq_pend);
        if (asleep_q) begin
            sleep_nx = !wake;
            src_nx   = src_q;
        end else begin
            sleep_nx = enter_irq || enter_evt;
            src_nx   = enter_evt ? WAKE_ON_EVT : WAKE_ON_IRQ;
        end
    end

    // Register sleep state, wake source and the core clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q  <= 1'b0;
            core_en_q <= 1'b1;
            src_q     <= WAKE_ON_IRQ;
        end else begin
            asleep_q  <= sleep_nx;
            core_en_q <= !sleep_nx;
            src_q     <= src_nx;
        end
    end

    assign evt_sleep_o = asleep_q && (src_q == WAKE_ON_EVT);
    assign sleep_nx_o  = sleep_nx;
    assign core_en_o   = core_en_q;
    assign asleep_o    = asleep_q;

    // R6: the deep-sleep select keeps an awake block awake.
    p_deep_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep_q && deep_sel) |=> !asleep_q);
    // R1: a wait-for-interrupt with an interrupt pending does not sleep.
    p_wfi_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep_q && wfi_req && irq_pend && !wfe_req) |=> !asleep_q);
    // R7: interrupt wakes an interrupt-wait sleep.
    p_wake_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && src_q == WAKE_ON_IRQ && irq_pend) |=> !asleep_q);
    // R8: an event wakes an event-wait sleep, and nothing else does.
    p_wake_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && src_q == WAKE_ON_EVT && evt_pend) |=> !asleep_q);
    p_hold_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && src_q == WAKE_ON_EVT && !evt_pend) |=> asleep_q);
    // R11: the status flag is the complement of the core clock enable.
    p_status_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q != core_en_q);

endmodule

// File: rtl/nap_periph_gate.sv
// Module: registered per-peripheral clock enables.
// Each bit follows its run-enable while awake. While asleep it also needs
// its nap-enable. The input is the next sleep state, so the gating changes
// on the same edge as the core clock enable.
// Assumes: N_PERIPH >= 1.
module nap_periph_gate #(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_nx,
    input  logic [N_PERIPH-1:0] run_en,
    input  logic [N_PERIPH-1:0] nap_en,
    output logic [N_PERIPH-1:0] en_o
);

    for (genvar i = 0; i < N_PERIPH; i++) begin : g_lane
        logic en_q;

        // One enable flop per peripheral; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q <= 1'b0;
            else
                en_q <= run_en[i] && (!sleep_nx || nap_en[i]);
        end

        assign en_o[i] = en_q;

        // R4: a lane without nap-enable is off while asleep.
        p_nap_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_nx && !nap_en[i]) |=> !en_q);
        // R5: a lane without run-enable is always off.
        p_run_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !run_en[i] |=> !en_q);
    end

endmodule

// File: rtl/nap_ctrl.sv
// Module: top of the light-sleep entry and clock gating controller.
// Connects the entry/wake FSM, the event holding register and the
// per-peripheral gate. It adds no logic of its own.
// Assumes: all inputs are synchronous to clk; the reset is synchronous
// and active low.
module nap_ctrl #(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wfi_req,
    input  logic                wfe_req,
    input  logic                deep_sel,
    input  logic                exit_nap,
    input  logic                exc_ret,
    input  logic                irq_pend,
    input  logic                evt_pend,
    input  logic [N_PERIPH-1:0] run_en,
    input  logic [N_PERIPH-1:0] nap_en,
    output logic                core_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                napping
);

    logic evt_held;
    logic consume;
    logic evt_sleep;
    logic sleep_nx;

    nap_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_req    (wfi_req),
        .wfe_req    (wfe_req),
        .deep_sel   (deep_sel),
        .exit_nap   (exit_nap),
        .exc_ret    (exc_ret),
        .irq_pend   (irq_pend),
        .evt_pend   (evt_pend),
        .evt_held   (evt_held),
        .consume_o  (consume),
        .evt_sleep_o(evt_sleep),
        .sleep_nx_o (sleep_nx),
        .core_en_o  (core_clk_en),
        .asleep_o   (napping)
    );

    nap_evt_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_pend),
        .consume_i  (consume),
        .evt_sleep_i(evt_sleep),
        .held_o     (evt_held)
    );

    nap_periph_gate #(.N_PERIPH(N_PERIPH)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_nx(sleep_nx),
        .run_en  (run_en),
        .nap_en  (nap_en),
        .en_o    (periph_clk_en)
    );

endmodule

// File: tb/nap_ctrl_tb.sv
// Bench: directed scenarios, one task each; every task checks its own results.
module nap_ctrl_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wfi_req = 1'b0, wfe_req = 1'b0, deep_sel = 1'b0;
    logic          exit_nap = 1'b0, exc_ret = 1'b0;
    logic          irq_pend = 1'b0, evt_pend = 1'b0;
    logic [NP-1:0] run_en = '0, nap_en = '0;
    logic          core_clk_en, napping;
    logic [NP-1:0] periph_clk_en;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nap_ctrl #(.N_PERIPH(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .deep_sel(deep_sel), .exit_nap(exit_nap), .exc_ret(exc_ret),
        .irq_pend(irq_pend), .evt_pend(evt_pend), .run_en(run_en),
        .nap_en(nap_en), .core_clk_en(core_clk_en),
        .periph_clk_en(periph_clk_en), .napping(napping)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected state: asleep flag, core enable, peripheral enables.
    task automatic expect_state(string tag, logic slp, logic [NP-1:0] pen);
        check({tag, " napping"}, 32'(napping), 32'(slp));
        check({tag, " core_clk_en (R11)"}, 32'(core_clk_en), 32'(!slp));
        check({tag, " periph_clk_en"}, 32'(periph_clk_en), 32'(pen));
    endtask

    task automatic t_reset();
        run_en = 4'b1111;
        tick();
        expect_state("R12 in reset", 1'b0, 4'b0000);
        rst_n = 1'b1;
        run_en = 4'b1010;
        check("R10 no change before edge", 32'(periph_clk_en), 32'h0);
        tick();
        expect_state("R5 awake follows run_en", 1'b0, 4'b1010);
    endtask

    task automatic t_wfi();
        run_en = 4'b0110; nap_en = 4'b0011;
        tick();
        wfi_req = 1'b1;
        #1 check("R10 wfi not yet visible", 32'(napping), 32'h0);
        tick();
        wfi_req = 1'b0;
        expect_state("R1 R4 R5 wfi sleep", 1'b1, 4'b0010);
        tick(); tick();
        expect_state("R1 stays asleep", 1'b1, 4'b0010);
        evt_pend = 1'b1; tick(); evt_pend = 1'b0;
        expect_state("R7 event ignored in irq sleep", 1'b1, 4'b0010);
        irq_pend = 1'b1; tick(); irq_pend = 1'b0;
        expect_state("R7 irq wakes", 1'b0, 4'b0110);
        irq_pend = 1'b1; wfi_req = 1'b1; tick(); wfi_req = 1'b0; irq_pend = 1'b0;
        expect_state("R1 wfi blocked by pending irq", 1'b0, 4'b0110);
    endtask

    task automatic t_wfe();
        // The event seen during the irq sleep above is still held.
        wfe_req = 1'b1; tick(); wfe_req = 1'b0;
        expect_state("R9 held event returns at once", 1'b0, 4'b0110);
        wfe_req = 1'b1; tick(); wfe_req = 1'b0;
        expect_state("R2 R9 wfe sleeps after consume", 1'b1, 4'b0010);
        irq_pend = 1'b1; tick(); irq_pend = 1'b0;
        expect_state("R8 irq ignored in event sleep", 1'b1, 4'b0010);
        evt_pend = 1'b1; tick(); evt_pend = 1'b0;
        expect_state("R8 event wakes", 1'b0, 4'b0110);
        evt_pend = 1'b1; wfe_req = 1'b1; tick(); wfe_req = 1'b0; evt_pend = 1'b0;
        expect_state("R2 wfe blocked by event", 1'b0, 4'b0110);
    endtask

    task automatic t_deep();
        deep_sel = 1'b1; exit_nap = 1'b1;
        wfi_req = 1'b1; tick(); wfi_req = 1'b0;
        expect_state("R6 deep blocks wfi", 1'b0, 4'b0110);
        wfe_req = 1'b1; tick(); wfe_req = 1'b0;
        expect_state("R6 deep blocks wfe", 1'b0, 4'b0110);
        exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        expect_state("R6 deep blocks exc_ret", 1'b0, 4'b0110);
        deep_sel = 1'b0;
    endtask

    task automatic t_exit();
        run_en = 4'b1111; nap_en = 4'b0101;
        exit_nap = 1'b0; exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        expect_state("R3 no sleep with exit_nap=0", 1'b0, 4'b1111);
        exit_nap = 1'b1; irq_pend = 1'b1; exc_ret = 1'b1; tick();
        exc_ret = 1'b0; irq_pend = 1'b0;
        expect_state("R3 no sleep with irq pending", 1'b0, 4'b1111);
        exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        expect_state("R3 R4 sleep on exception return", 1'b1, 4'b0101);
        evt_pend = 1'b1; tick(); evt_pend = 1'b0;
        expect_state("R7 event does not wake exit sleep", 1'b1, 4'b0101);
        irq_pend = 1'b1; tick(); irq_pend = 1'b0;
        expect_state("R7 irq wakes exit sleep", 1'b0, 4'b1111);
        run_en = 4'b0000; tick();
        expect_state("R5 run_en off", 1'b0, 4'b0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wfi();
        t_wfe();
        t_deep();
        t_exit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule